// File: doc/BRIEF.md
# Addressed Serial Configuration Loader

This block takes configuration from a three-wire serial port (a shift clock, a data line and a framing strobe) and turns it into the register fields that drive a fractional-N synthesizer. The shift clock and the data line are used while the strobe is low. The rising edge of the strobe ends a word. The loader then counts the bits received, decodes the address at the head of the word and writes the payload into the registers for that address.

Four kinds of configuration word carry a four-bit address. The divider word carries a one-bit address and comes in two lengths, chosen by a format flag set earlier. The gain and prescaler-mode fields of the prescaler word are held in a staging register. They reach the working outputs only when a divider word is committed. A divider word is not committed when it arrives. It waits, marked pending, until the main divider asserts its load window, so the divider never sees a mixed set of ratios. For as long as the strobe stays high after a divider word, an acceleration flag is raised for the loop.

All serial pins pass through two-flop synchronisers into the system clock domain. The word length and the address are decided in the cycle in which the synchronised strobe is seen to rise.

Top module: `prog_loader`

## Requirements
- R1: After reset every output is zero.
- R2: A bit is shifted in (first bit ends up most significant) on each rising shift-clock edge only while the strobe is low. Shift-clock edges while the strobe is high are not counted and leave the next word unaffected.
- R3: A word is accepted only if exactly 24 or 32 bits arrived since the previous strobe rise. Any other count, or a 32-bit word whose top bit is 1, is discarded and changes no output.
- R4: A 24-bit word starting 1000 is the prescaler word, laid out as {1000, gain[7:0], prop_accel[1:0], int_accel[3:0], mode[1:0], 4 spare}. prop_accel and int_accel update at once. gain and mode go only to the staging register, and cp_gain and psc_mode do not change.
- R5: A 24-bit word starting 1001 is the auxiliary word, laid out as {1001, aux_div[11:0], aux_bypass, aux_ref_sel[1:0], aux_en, 4 spare}.
- R6: A 24-bit word starting 1010 is the reference word, laid out as {1010, ref_div[11:0], main_ref_sel[1:0], main_en, frac_mod8, a_long, 3 spare}. It also clears test_sel to 00.
- R7: A 24-bit word starting 1111 is the test word, laid out as {1111, test_sel[1:0], 18 spare}.
- R8: With a_long=0 the divider word is 24 bits, laid out as {0, cnt_lo[11:0], split[7:0], frac_inc[2:0]}. On commit, cp_gain and psc_mode take the staged gain and mode. With a_long=0, a 32-bit divider word is discarded.
- R9: With a_long=1 the divider word is 32 bits, laid out as {0, gain[7:0], cnt_lo[11:0], split[7:0], frac_inc[2:0]}. On commit, cp_gain takes the gain from the word and psc_mode takes the staged mode.
- R10: An accepted divider word stays pending, and the divider outputs hold, until a cycle with load_win high. The commit lands on that clock edge. A later divider word that arrives before the window replaces the pending one.
- R11: speedup goes high when a divider word is accepted and returns to 0 within three clocks of the strobe pin going low. Other words do not raise it.
- R12: With psc_mode=10, cnt_mid is split[7:4] and cnt_hi is split[3:0]. With any other mode, cnt_mid is split[7:0] and cnt_hi is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_strobe | input | 1 | Serial framing strobe, high ends a word |
| load_win | input | 1 | Main divider load window |
| cnt_lo | output | 12 | Cycles at the lowest prescaler ratio |
| cnt_mid | output | 8 | Cycles at the middle prescaler ratio |
| cnt_hi | output | 4 | Cycles at the highest prescaler ratio |
| psc_mode | output | 2 | Prescaler mode |
| frac_inc | output | 3 | Fractional increment |
| frac_mod8 | output | 1 | Fractional modulus select, 1 = eight |
| cp_gain | output | 8 | Main charge-pump gain |
| prop_accel | output | 2 | Proportional acceleration factor |
| int_accel | output | 4 | Integral acceleration factor |
| main_en | output | 1 | Main path enable |
| aux_en | output | 1 | Auxiliary path enable |
| main_ref_sel | output | 2 | Main reference tap select |
| aux_ref_sel | output | 2 | Auxiliary reference tap select |
| ref_div | output | 12 | Reference divide ratio |
| aux_div | output | 12 | Auxiliary divide ratio |
| aux_bypass | output | 1 | Auxiliary pre-divider bypass |
| a_long | output | 1 | Divider word format, 1 = 32-bit |
| test_sel | output | 2 | Test output select |
| speedup | output | 1 | Loop acceleration flag |

## Verification
A pin change reaches the decode logic after two synchroniser flops and one edge-detect flop. The field outputs therefore change on the third clock edge after the strobe pin rises. The bench drives pins on falling clock edges and samples at least eight cycles after the strobe rises. A commit lands on the first edge at which load_win is high with a word pending, and the bench holds the window for exactly one edge and samples three cycles later. speedup is sampled five cycles after the strobe pin falls, which leaves margin over the three edges it needs to clear.

// File: rtl/prog_loader.sv
module prog_loader #(
  parameter int SHORT_BITS = 24,
  parameter int LONG_BITS  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_strobe,
  input  logic        load_win,
  output logic [11:0] cnt_lo,
  output logic [7:0]  cnt_mid,
  output logic [3:0]  cnt_hi,
  output logic [1:0]  psc_mode,
  output logic [2:0]  frac_inc,
  output logic        frac_mod8,
  output logic [7:0]  cp_gain,
  output logic [1:0]  prop_accel,
  output logic [3:0]  int_accel,
  output logic        main_en,
  output logic        aux_en,
  output logic [1:0]  main_ref_sel,
  output logic [1:0]  aux_ref_sel,
  output logic [11:0] ref_div,
  output logic [11:0] aux_div,
  output logic        aux_bypass,
  output logic        a_long,
  output logic [1:0]  test_sel,
  output logic        speedup
);
  localparam int CNT_W = $clog2(LONG_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LONG_BITS + 1);

  logic [1:0] clk_sy, dat_sy, stb_sy;
  logic       clk_q, stb_q;
  logic [LONG_BITS-1:0] shreg;
  logic [CNT_W-1:0]     bitcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sy <= '0; dat_sy <= '0; stb_sy <= '0;
      clk_q  <= 1'b0; stb_q <= 1'b0;
    end else begin
      clk_sy <= {clk_sy[0], ser_clk};
      dat_sy <= {dat_sy[0], ser_data};
      stb_sy <= {stb_sy[0], ser_strobe};
      clk_q  <= clk_sy[1];
      stb_q  <= stb_sy[1];
    end

  wire shift_en = clk_sy[1] & ~clk_q & ~stb_sy[1];
  wire stb_rise = stb_sy[1] & ~stb_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (stb_rise) begin
      bitcnt <= '0;
    end else if (shift_en) begin
      shreg <= {shreg[LONG_BITS-2:0], dat_sy[1]};
      if (bitcnt != CNT_SAT) bitcnt <= bitcnt + 1'b1;
    end

  wire [SHORT_BITS-1:0] sw = shreg[SHORT_BITS-1:0];
  wire [3:0] s_addr = sw[SHORT_BITS-1 -: 4];
  wire is_short = (bitcnt == CNT_W'(SHORT_BITS));
  wire is_long  = (bitcnt == CNT_W'(LONG_BITS));
  wire hit_a0 = stb_rise & is_short & ~sw[SHORT_BITS-1] & ~a_long;
  wire hit_a1 = stb_rise & is_long & ~shreg[LONG_BITS-1] & a_long;
  wire hit_b  = stb_rise & is_short & (s_addr == 4'b1000);
  wire hit_c  = stb_rise & is_short & (s_addr == 4'b1001);
  wire hit_d  = stb_rise & is_short & (s_addr == 4'b1010);
  wire hit_e  = stb_rise & is_short & (s_addr == 4'b1111);
  wire unused_bits = ^{sw[3:0], sw[17:0]};

  logic [7:0] gain_stg;
  logic [1:0] mode_stg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gain_stg <= '0; mode_stg <= '0;
      prop_accel <= '0; int_accel <= '0;
    end else if (hit_b) begin
      gain_stg   <= sw[19:12];
      prop_accel <= sw[11:10];
      int_accel  <= sw[9:6];
      mode_stg   <= sw[5:4];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      aux_div <= '0; aux_bypass <= 1'b0; aux_ref_sel <= '0; aux_en <= 1'b0;
    end else if (hit_c) begin
      aux_div     <= sw[19:8];
      aux_bypass  <= sw[7];
      aux_ref_sel <= sw[6:5];
      aux_en      <= sw[4];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_div <= '0; main_ref_sel <= '0; main_en <= 1'b0;
      frac_mod8 <= 1'b0; a_long <= 1'b0; test_sel <= '0;
    end else if (hit_d) begin
      ref_div      <= sw[19:8];
      main_ref_sel <= sw[7:6];
      main_en      <= sw[5];
      frac_mod8    <= sw[4];
      a_long       <= sw[3];
      test_sel     <= 2'b00;
    end else if (hit_e) begin
      test_sel <= sw[19:18];
    end

  logic        pend, pend_direct;
  logic [11:0] pend_lo;
  logic [7:0]  pend_split, pend_gain;
  logic [2:0]  pend_frac;
  logic [7:0]  split_q;
  wire commit = pend & load_win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= 1'b0; pend_direct <= 1'b0; pend_lo <= '0;
      pend_split <= '0; pend_gain <= '0; pend_frac <= '0;
    end else if (hit_a0 || hit_a1) begin
      pend        <= 1'b1;
      pend_direct <= hit_a1;
      pend_lo     <= sw[22:11];
      pend_split  <= sw[10:3];
      pend_frac   <= sw[2:0];
      pend_gain   <= shreg[30:23];
    end else if (commit) begin
      pend <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_lo <= '0; split_q <= '0; frac_inc <= '0; cp_gain <= '0; psc_mode <= '0;
    end else if (commit) begin
      cnt_lo   <= pend_lo;
      split_q  <= pend_split;
      frac_inc <= pend_frac;
      cp_gain  <= pend_direct ? pend_gain : gain_stg;
      psc_mode <= mode_stg;
    end

  assign cnt_mid = (psc_mode == 2'b10) ? {4'b0000, split_q[7:4]} : split_q;
  assign cnt_hi  = (psc_mode == 2'b10) ? split_q[3:0] : 4'b0000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 speedup <= 1'b0;
    else if (hit_a0 || hit_a1)  speedup <= 1'b1;
    else if (!stb_sy[1])        speedup <= 1'b0;

  assert_commit_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_lo) |-> $past(load_win));

  assert_cfg_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({aux_div, ref_div, prop_accel, int_accel}) |-> $past(stb_rise));

  assert_test_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_d) |-> (test_sel == 2'b00));

  assert_speed_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    speedup |-> $past(stb_sy[1]));
endmodule

// File: tb/tb_prog_loader.sv
module tb_prog_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b1, load_win = 1'b0;
  logic [11:0] cnt_lo, ref_div, aux_div;
  logic [7:0]  cnt_mid, cp_gain;
  logic [3:0]  cnt_hi, int_accel;
  logic [1:0]  psc_mode, prop_accel, main_ref_sel, aux_ref_sel, test_sel;
  logic [2:0]  frac_inc;
  logic frac_mod8, main_en, aux_en, aux_bypass, a_long, speedup;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prog_loader dut (.*);

  localparam logic [15:0] CTAB [3] = '{ {12'hABC, 1'b1, 2'b10, 1'b1},
                                        {12'h004, 1'b0, 2'b01, 1'b0},
                                        {12'hFFF, 1'b1, 2'b11, 1'b1} };
  localparam logic [16:0] DTAB [3] = '{ {12'hFFF, 2'b11, 1'b1, 1'b1, 1'b1},
                                        {12'h123, 2'b01, 1'b0, 1'b1, 1'b0},
                                        {12'hA5A, 2'b10, 1'b1, 1'b0, 1'b0} };

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input int len, input int extra = 0);
    ser_strobe = 1'b0; tick(4);
    for (int i = len - 1; i >= 0; i--) begin
      ser_data = w[i]; tick(4);
      ser_clk = 1'b1; tick(4);
      ser_clk = 1'b0;
    end
    tick(4); ser_strobe = 1'b1; tick(4);
    for (int k = 0; k < extra; k++) begin
      ser_clk = 1'b1; tick(4); ser_clk = 1'b0; tick(4);
    end
    tick(6);
  endtask

  task automatic window();
    load_win = 1'b1; tick(1); load_win = 1'b0; tick(3);
  endtask

  function automatic logic [31:0] mk_a0(logic [11:0] lo, logic [7:0] sp, logic [2:0] f);
    return {8'h0, 1'b0, lo, sp, f};
  endfunction
  function automatic logic [31:0] mk_a1(logic [7:0] g, logic [11:0] lo, logic [7:0] sp, logic [2:0] f);
    return {1'b0, g, lo, sp, f};
  endfunction
  function automatic logic [31:0] mk_b(logic [7:0] g, logic [1:0] cl, logic [3:0] ck, logic [1:0] m);
    return {8'h0, 4'b1000, g, cl, ck, m, 4'b0};
  endfunction
  function automatic logic [31:0] mk_c(logic [15:0] f);
    return {8'h0, 4'b1001, f, 4'b0};
  endfunction
  function automatic logic [31:0] mk_d(logic [16:0] f);
    return {8'h0, 4'b1010, f, 3'b0};
  endfunction

  wire [15:0] obs_c = {aux_div, aux_bypass, aux_ref_sel, aux_en};
  wire [16:0] obs_d = {ref_div, main_ref_sel, main_en, frac_mod8, a_long};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(3);
    chk("R1 reset", {cnt_lo, cnt_mid, cnt_hi, psc_mode, frac_inc, frac_mod8, cp_gain,
                     prop_accel, int_accel, main_en, aux_en, main_ref_sel, aux_ref_sel},
        32'h0);
    chk("R1 reset2", {ref_div, aux_div, aux_bypass, a_long, test_sel, speedup}, 32'h0);

    for (int i = 0; i < 3; i++) begin
      send(mk_c(CTAB[i]), 24);
      chk("R5 aux word", 32'(obs_c), 32'(CTAB[i]));
      send(mk_d(DTAB[i]), 24);
      chk("R6 ref word", 32'(obs_d), 32'(DTAB[i]));
    end

    send({8'h0, 4'b1111, 2'b11, 18'h0}, 24);
    chk("R7 test word", 32'(test_sel), 32'h3);
    send(mk_d(DTAB[2]), 24);
    chk("R6 test cleared", 32'(test_sel), 32'h0);

    send(mk_b(8'hA5, 2'b10, 4'h9, 2'b10), 24);
    chk("R4 accel", {prop_accel, int_accel}, {26'h0, 2'b10, 4'h9});
    chk("R4 staged", {cp_gain, psc_mode}, 32'h0);
    chk("R11 no speedup", 32'(speedup), 32'h0);

    send(mk_a0(12'h123, 8'h5C, 3'd5), 24);
    chk("R10 pending hold", 32'(cnt_lo), 32'h0);
    chk("R11 speedup high", 32'(speedup), 32'h1);
    ser_strobe = 1'b0; tick(5);
    chk("R11 speedup drop", 32'(speedup), 32'h0);
    ser_strobe = 1'b1; tick(8);
    window();
    chk("R8 commit lo/frac", {cnt_lo, frac_inc}, {17'h0, 12'h123, 3'd5});
    chk("R8 staged gain", {cp_gain, psc_mode}, {22'h0, 8'hA5, 2'b10});
    chk("R12 split mode10", {cnt_mid, cnt_hi}, {20'h0, 8'h05, 4'hC});

    send(mk_c(16'h1234), 23);
    chk("R3 short discard", 32'(obs_c), 32'(CTAB[2]));
    send(mk_c(16'h1234), 25);
    chk("R3 25 discard", 32'(obs_c), 32'(CTAB[2]));
    send({4'b1001, 16'h1234, 12'h0}, 32);
    chk("R3 long nonA discard", 32'(obs_c), 32'(CTAB[2]));
    send(mk_a1(8'h77, 12'h456, 8'h11, 3'd1), 32);
    chk("R8 long A rejected", 32'(speedup), 32'h0);
    window();
    chk("R8 long A no commit", 32'(cnt_lo), 32'h123);

    send(mk_d(DTAB[2]), 24, 3);
    send(mk_c(CTAB[1]), 24);
    chk("R2 clocks ignored", 32'(obs_c), 32'(CTAB[1]));

    send(mk_d({12'h321, 2'b00, 1'b1, 1'b1, 1'b1}), 24);
    chk("R6 long set", 32'(a_long), 32'h1);
    send(mk_b(8'h11, 2'b01, 4'h3, 2'b01), 24);
    load_win = 1'b1;
    send(mk_a1(8'h3C, 12'h7FF, 8'h9A, 3'd2), 32);
    load_win = 1'b0; tick(2);
    chk("R9 direct gain", {cp_gain, psc_mode, cnt_lo}, {10'h0, 8'h3C, 2'b01, 12'h7FF});
    chk("R12 split mode01", {cnt_mid, cnt_hi}, {20'h0, 8'h9A, 4'h0});

    send(mk_a1(8'h01, 12'h100, 8'h00, 3'd0), 32);
    send(mk_a1(8'h02, 12'h200, 8'h00, 3'd0), 32);
    chk("R10 still held", 32'(cnt_lo), 32'h7FF);
    window();
    chk("R10 replaced", {cp_gain, cnt_lo}, {12'h0, 8'h02, 12'h200});

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule